// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits beside a three-phase PWM timer and forces every gate output off when a fault appears. Three sources can trip it: an active-low external trip pin, an active-high over-range flag from the current-sense comparators, and a software write on a small register bus. The disable output is an OR of the raw fault levels and a shutdown latch. Because of this, a hardware fault turns the outputs off at once, without waiting for a clock edge. The latch then holds the shutdown after the fault goes away.

While the block is shut down it also blocks the PWM sync pulse, and the interrupt that pulse drives, from reaching the rest of the system. On entry to shutdown it raises a one-cycle trip interrupt. Software can read two things over the bus: whether the last shutdown came from a software write (a flag that clears on read), and the synchronized level of the trip pin.

Recovery needs three things. The fault must be gone, the period register and each of the three duty registers must be rewritten after that, and then a rising edge of the sync input must arrive. The outputs come back on at that sync edge. The block starts out of reset in the shutdown state, so the same rewrite-and-sync sequence brings the PWM up for the first time.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: After reset the block is shut down: `out_dis_o`=1, `trip_irq_o`=0, the software-trip flag reads 0, and the rewrite mask is empty. Reset alone raises no trip interrupt.
- R2: While `trip_n_i` is 0, `out_dis_o` is 1 in the same instant, with no clock edge needed.
- R3: While `sense_fault_i` is 1, `out_dis_o` is 1 in the same instant. Once the synchronizer carries the fault, it latches a shutdown exactly as the trip pin does.
- R4: A bus write to address 0 (the software-trip register) causes a shutdown that is visible after the clock edge that takes the write, whatever else is happening.
- R5: A bus read at address 0 returns, in bit 0, 1 if the latest shutdown came from a software write and 0 if it came from hardware. The same read clears the flag. Upper data bits read 0.
- R6: A bus read at address 1 returns in bit 0 the level of `trip_n_i`, taken through a two-flop synchronizer.
- R7: `trip_irq_o` is a single-cycle pulse, produced once for each entry into shutdown from the running state. It does not repeat while a fault persists or while the block is already shut down.
- R8: `sync_pass_o` follows `sync_i` only while `out_dis_o` is 0. It is 0 at all other times.
- R9: Outputs re-enable only on a rising edge of `sync_i`, and only if the synchronized fault is clear and all four rewrite strobes (bit 0 period, bits 1..3 duty of phases 0..2) have been seen. A `sync_i` level that is already high when the last condition is met does not re-enable.
- R10: The rewrite mask is emptied by every trip event, including software trips and every cycle in which a hardware fault is present. Rewrites made while a fault is present therefore do not count.
- R11: If any one or more of the four rewrite strobes is missing, a sync rising edge leaves the outputs disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_n_i | input | 1 | External trip, active low, asynchronous |
| sense_fault_i | input | 1 | Current-sense over-range flag, active high |
| sync_i | input | 1 | PWM sync pulse from the timer |
| rewrite_stb_i | input | NUM_PHASES+1 | One-cycle strobes: bit 0 period write, bits 1.. duty writes |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 1 | Register select: 0 software trip, 1 status |
| bus_rdata_o | output | DATA_W | Registered read data |
| out_dis_o | output | 1 | Global PWM output disable |
| sync_pass_o | output | 1 | Gated sync pulse, also used to drive the sync interrupt |
| trip_irq_o | output | 1 | One-cycle trip interrupt |

## Verification
The bench moves the fault between the clock edges and checks the disable output before any edge arrives. A design that put the disable path through a register would be caught by that check. It counts trip interrupts across long fault windows, so an interrupt that fires on the fault level, rather than on entry to shutdown, shows up as extra pulses. It tries every incomplete set of rewrite strobes, rewrites made while a fault is still held, and a sync input that is already high when the rewrites complete; a controller that checks the wrong mask bits, or re-arms on the sync level instead of its edge, would re-enable too early in one of these. Reading the software-trip flag twice, after both software and hardware trips, exposes a flag that is not cleared by the read or is blamed on the wrong source.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  typedef enum logic [0:0] {
    REG_SWTRIP = 1'b0,
    REG_STATUS = 1'b1
  } trip_reg_e;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rewrite_tracker.sv
module rewrite_tracker #(
  parameter int NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic [NUM_REGS-1:0] stb_i,
  output logic                full_o
);
  logic [NUM_REGS-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) seen_q <= '0;
    else              seen_q <= seen_q | stb_i;
  end

  assign full_o = &seen_q;
endmodule

// File: rtl/swtrip_flag.sv
module swtrip_flag
  import pwm_trip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr_i,
  input  logic              rd_i,
  input  logic [0:0]        addr_i,
  input  logic              hw_entry_i,
  input  logic              pin_level_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic flag_q;
  logic rd_sw;

  assign rd_sw = rd_i && (trip_reg_e'(addr_i) == REG_SWTRIP);

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (sw_wr_i)    flag_q <= 1'b1;
    else if (rd_sw)      flag_q <= 1'b0;
    else if (hw_entry_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= '0;
      case (trip_reg_e'(addr_i))
        REG_SWTRIP: rdata_o[0] <= flag_q;
        REG_STATUS: rdata_o[0] <= pin_level_i;
        default:    rdata_o[0] <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NUM_PHASES  = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trip_n_i,
  input  logic                  sense_fault_i,
  input  logic                  sync_i,
  input  logic [NUM_PHASES:0]   rewrite_stb_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [0:0]            bus_addr_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  out_dis_o,
  output logic                  sync_pass_o,
  output logic                  trip_irq_o
);
  localparam int NUM_REGS = NUM_PHASES + 1;

  logic [1:0] lvl_s;
  logic       pin_s;
  logic       fault_clear_s;
  logic       sw_wr;
  logic       trip_ev;
  logic       hw_entry;
  logic       mask_full;
  logic       sync_q;
  logic       sync_rise;
  logic       rearm;
  logic       shut_q;
  logic       irq_q;

  // Bit 1: trip pin level, bit 0: sense input healthy.
  trip_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({trip_n_i, ~sense_fault_i}),
    .q_o (lvl_s)
  );

  assign pin_s         = lvl_s[1];
  assign fault_clear_s = &lvl_s;
  assign sw_wr         = bus_wr_i && (trip_reg_e'(bus_addr_i) == REG_SWTRIP);
  assign trip_ev       = !fault_clear_s || sw_wr;
  assign hw_entry      = !shut_q && !fault_clear_s;

  rewrite_tracker #(.NUM_REGS(NUM_REGS)) u_track (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (trip_ev || rearm),
    .stb_i  (rewrite_stb_i),
    .full_o (mask_full)
  );

  swtrip_flag #(.DATA_W(DATA_W)) u_flag (
    .clk         (clk),
    .rst         (rst),
    .sw_wr_i     (sw_wr),
    .rd_i        (bus_rd_i),
    .addr_i      (bus_addr_i),
    .hw_entry_i  (hw_entry),
    .pin_level_i (pin_s),
    .rdata_o     (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_i;
  end

  assign sync_rise = sync_i && !sync_q;
  assign rearm     = shut_q && fault_clear_s && mask_full && sync_rise && !sw_wr;

  always_ff @(posedge clk) begin
    if (rst)          shut_q <= 1'b1;
    else if (trip_ev) shut_q <= 1'b1;
    else if (rearm)   shut_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= !shut_q && trip_ev;
  end

  // Raw fault levels bypass every flop so the disable needs no clock.
  assign out_dis_o   = shut_q || !trip_n_i || sense_fault_i;
  assign sync_pass_o = sync_i && !out_dis_o;
  assign trip_irq_o  = irq_q;
endmodule

// File: rtl/pwm_trip_ctrl_chk.sv
module pwm_trip_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic trip_n_i,
  input logic sense_fault_i,
  input logic sync_i,
  input logic bus_wr_i,
  input logic [0:0] bus_addr_i,
  input logic out_dis_o,
  input logic sync_pass_o,
  input logic trip_irq_o
);
  assert_pin_disables_R2: assert property (@(posedge clk) disable iff (rst)
    !trip_n_i |-> out_dis_o);

  assert_sense_disables_R3: assert property (@(posedge clk) disable iff (rst)
    sense_fault_i |-> out_dis_o);

  assert_sw_write_trips_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == 1'b0) |=> out_dis_o);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    trip_irq_o |=> !trip_irq_o);

  assert_sync_gated_R8: assert property (@(posedge clk) disable iff (rst)
    out_dis_o |-> !sync_pass_o);

  assert_rearm_on_sync_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(out_dis_o) |-> $past(sync_i));
endmodule

bind pwm_trip_ctrl pwm_trip_ctrl_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .trip_n_i      (trip_n_i),
  .sense_fault_i (sense_fault_i),
  .sync_i        (sync_i),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .out_dis_o     (out_dis_o),
  .sync_pass_o   (sync_pass_o),
  .trip_irq_o    (trip_irq_o)
);

// File: tb/test_pwm_trip_ctrl.sv
`timescale 1ns/1ps
module test_pwm_trip_ctrl;
  localparam int NP = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trip_n_i = 1'b1;
  logic          sense_fault_i = 1'b0;
  logic          sync_i = 1'b0;
  logic [NP:0]   rewrite_stb_i = '0;
  logic          bus_wr_i = 1'b0;
  logic          bus_rd_i = 1'b0;
  logic [0:0]    bus_addr_i = 1'b0;
  logic [DW-1:0] bus_rdata_o;
  logic          out_dis_o;
  logic          sync_pass_o;
  logic          trip_irq_o;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  logic [DW-1:0] rv;

  always #5 clk = ~clk;

  pwm_trip_ctrl #(.NUM_PHASES(NP), .DATA_W(DW)) i_pwm_trip_ctrl (
    .clk(clk), .rst(rst), .trip_n_i(trip_n_i), .sense_fault_i(sense_fault_i),
    .sync_i(sync_i), .rewrite_stb_i(rewrite_stb_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
    .out_dis_o(out_dis_o), .sync_pass_o(sync_pass_o), .trip_irq_o(trip_irq_o)
  );

  always @(negedge clk) if (trip_irq_o) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [0:0] a);
    @(negedge clk); bus_wr_i = 1'b1; bus_addr_i = a;
    @(negedge clk); bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [0:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk); bus_rd_i = 1'b0; d = bus_rdata_o;
  endtask

  task automatic rewrite(input logic [NP:0] v);
    @(negedge clk); rewrite_stb_i = v;
    @(negedge clk); rewrite_stb_i = '0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    check("R1 out_dis after reset", out_dis_o, 1);
    check("R1 no irq after reset", irq_cnt, 0);
    bus_read(1'b0, rv);
    check("R1 sw flag after reset", rv, 0);
    // R8: sync blocked while shut down
    sync_i = 1'b1; #1;
    check("R8 sync blocked", sync_pass_o, 0);
    cyc(1); sync_i = 1'b0;
    // R9: start-up sequence
    rewrite('1);
    pulse_sync();
    check("R9 enabled after rewrites and sync", out_dis_o, 0);
    @(negedge clk); sync_i = 1'b1; #1;
    check("R8 sync passes when enabled", sync_pass_o, 1);
    @(negedge clk); sync_i = 1'b0;

    // R2: pin trip acts without a clock edge
    irq_cnt = 0;
    @(negedge clk); #2 trip_n_i = 1'b0; #1;
    check("R2 immediate disable", out_dis_o, 1);
    cyc(20);
    check("R7 single irq on pin trip", irq_cnt, 1);
    bus_read(1'b1, rv);
    check("R6 status pin low", rv, 0);
    bus_read(1'b0, rv);
    check("R5 hw trip flag", rv, 0);
    rewrite('1); // R10: during fault, must not count
    trip_n_i = 1'b1;
    cyc(4);
    bus_read(1'b1, rv);
    check("R6 status pin high", rv, 1);
    pulse_sync();
    check("R10 rewrites during fault ignored", out_dis_o, 1);
    rewrite('1);
    pulse_sync();
    check("R9 restart after pin trip", out_dis_o, 0);

    // R3: sense fault
    irq_cnt = 0;
    @(negedge clk); #3 sense_fault_i = 1'b1; #1;
    check("R3 immediate disable", out_dis_o, 1);
    cyc(15);
    check("R7 single irq on sense trip", irq_cnt, 1);
    sense_fault_i = 1'b0;
    cyc(4);
    check("R3 latched after sense clears", out_dis_o, 1);
    rewrite('1);
    pulse_sync();
    check("R9 restart after sense trip", out_dis_o, 0);

    // R4, R5: software trip
    irq_cnt = 0;
    bus_write(1'b0);
    check("R4 sw trip disables", out_dis_o, 1);
    bus_write(1'b0); // already shut down: no second irq
    cyc(5);
    check("R7 one irq for sw trips", irq_cnt, 1);
    bus_read(1'b0, rv);
    check("R5 sw flag set", rv, 1);
    bus_read(1'b0, rv);
    check("R5 sw flag cleared by read", rv, 0);

    // R11: every incomplete rewrite set blocks restart
    for (int m = 0; m < (1 << (NP + 1)) - 1; m++) begin
      bus_write(1'b0);
      rewrite(m[NP:0]);
      pulse_sync();
      check("R11 partial rewrite blocks", out_dis_o, 1);
    end
    // R10: a new trip empties the mask
    rewrite('1);
    bus_write(1'b0);
    pulse_sync();
    check("R10 trip clears mask", out_dis_o, 1);
    // R9: sync already high when mask completes -> no edge, stay off
    @(negedge clk); sync_i = 1'b1;
    rewrite('1);
    cyc(2);
    check("R9 no rearm on sync level", out_dis_o, 1);
    @(negedge clk); sync_i = 1'b0;
    pulse_sync();
    check("R9 rearm on next sync edge", out_dis_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule